// File: doc/BRIEF.md
# Quaternary Signed-Digit Adder/Subtractor

This block adds or subtracts two N-digit radix-4 signed-digit operands. Each digit takes one of the values -3 to +3, so a value has more than one valid spelling. That redundancy lets every digit position settle on its own. Each position looks only at its own operand digits and at the position directly below it, so the path from input to output has the same depth for any N.

The work is split into two stages. In the first stage each position adds its two digits and splits the raw total into a small carry and a small remainder. In the second stage each position adds its remainder to the carry from the position below, which never produces a new carry. For subtraction, each digit of the second operand is negated before the first stage. An optional register holds the N+1 digit result. No binary conversion or normalisation is done here.

Top module: `qsd_adder`

## Requirements
- R1: With the output register enabled (parameter `REG_OUT` = 1, the default), an active-low `rst_n` drives every bit of `sum_o` to 0 (all digits zero), whatever the inputs are.
- R2: Digit i of every vector sits at bits [3i+2:3i] as a 3-bit two's-complement value in -3..+3. No output digit ever carries the code 3'b100.
- R3: With `sub_i` = 0, the weighted sum of the `sum_o` digits (digit times 4^i) equals the weighted sum of `a_i` plus that of `b_i`.
- R4: With `sub_i` = 1, the weighted value of `sum_o` equals the value of `a_i` minus that of `b_i`. It is formed by negating each digit of `b_i`, with no borrow chain.
- R5: Output digit 0 is the first-stage remainder of position 0. The raw total r = a0 ± b0 becomes r-4 if r >= 3, r+4 if r <= -3, and r otherwise.
- R6: Output digit N is the first-stage carry of position N-1, sign-extended: +1 when that position's raw total is >= 3, -1 when it is <= -3, and 0 otherwise.
- R7: Output digit i, for 1 <= i <= N-1, is the first-stage remainder of position i plus the first-stage carry of position i-1.
- R8: With `REG_OUT` = 1, `sum_o` shows the result of the inputs sampled at the previous rising edge of `clk` and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| sub_i | input | 1 | 0 selects a + b, 1 selects a - b |
| a_i | input | 3*N | First operand, N signed digits |
| b_i | input | 3*N | Second operand, N signed digits |
| sum_o | output | 3*(N+1) | Result, N+1 signed digits |

## Verification
A two-digit instance is driven with every pair of legal operands under both operation codes. This covers each raw total from -6 to +6 at both the low and the top position, including the +3/-3 boundaries where the carry choice flips. A four-digit instance gets operands that are all +3, all -3, mixed in sign, and zero, plus random digit mixes. These show that the full-width value comes out right when every position carries in the same direction. Each result is compared both as an integer and digit by digit against the split rule, which separates a wrong carry choice from a wrong value. The reset state and the one-edge latency are checked on the register.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
    localparam int DIGIT_W = 3;
    localparam int CARRY_W = 2;
    localparam int RAW_W   = DIGIT_W + 1;

    typedef logic signed [DIGIT_W-1:0] digit_t;
    typedef logic signed [CARRY_W-1:0] carry_t;
    typedef logic signed [RAW_W-1:0]   raw_t;

    localparam digit_t DIGIT_ZERO = '0;
    localparam digit_t DIGIT_BAD  = 3'b100;

    localparam raw_t RAW_HI   = 4'sd3;
    localparam raw_t RAW_LO   = -4'sd3;
    localparam raw_t RADIX    = 4'sd4;

    localparam carry_t CARRY_POS  = 2'sb01;
    localparam carry_t CARRY_NEG  = 2'sb11;
    localparam carry_t CARRY_ZERO = 2'sb00;
endpackage

// File: rtl/qsd_operand_sel.sv
module qsd_operand_sel
    import qsd_pkg::*;
#(
    parameter int N = 4,
    localparam int VEC_W = N * DIGIT_W
) (
    input  logic             neg_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [VEC_W-1:0] vec_o
);
    for (genvar g = 0; g < N; g++) begin : g_digit
        digit_t src;
        digit_t res;
        assign src = digit_t'(vec_i[g*DIGIT_W +: DIGIT_W]);
        always_comb begin
            if (neg_i) begin
                res = digit_t'(-src);
            end else begin
                res = src;
            end
        end
        assign vec_o[g*DIGIT_W +: DIGIT_W] = res;
    end
endmodule

// File: rtl/qsd_digit_split.sv
module qsd_digit_split
    import qsd_pkg::*;
(
    input  digit_t x_i,
    input  digit_t y_i,
    output carry_t carry_o,
    output digit_t part_o
);
    raw_t raw;
    raw_t adj;

    always_comb begin
        raw = raw_t'(x_i) + raw_t'(y_i);
        if (raw >= RAW_HI) begin
            carry_o = CARRY_POS;
            adj     = raw - RADIX;
        end else if (raw <= RAW_LO) begin
            carry_o = CARRY_NEG;
            adj     = raw + RADIX;
        end else begin
            carry_o = CARRY_ZERO;
            adj     = raw;
        end
        part_o = digit_t'(adj[DIGIT_W-1:0]);
    end
endmodule

// File: rtl/qsd_digit_merge.sv
module qsd_digit_merge
    import qsd_pkg::*;
(
    input  digit_t part_i,
    input  carry_t carry_i,
    output digit_t digit_o
);
    digit_t carry_ext;

    always_comb begin
        carry_ext = digit_t'(carry_i);
        digit_o   = part_i + carry_ext;
    end
endmodule

// File: rtl/qsd_adder.sv
module qsd_adder
    import qsd_pkg::*;
#(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int OPER_W = N * DIGIT_W,
    localparam int RES_W  = (N + 1) * DIGIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_i,
    input  logic [OPER_W-1:0] a_i,
    input  logic [OPER_W-1:0] b_i,
    output logic [RES_W-1:0]  sum_o
);
    typedef struct packed {
        logic [RES_W-1:0] result;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    logic [OPER_W-1:0] b_eff;
    logic [RES_W-1:0]  res_next;

    carry_t carry [N];
    digit_t part  [N];
    digit_t merged[N];

    qsd_operand_sel #(.N(N)) u_opsel (
        .neg_i (sub_i),
        .vec_i (b_i),
        .vec_o (b_eff)
    );

    for (genvar g = 0; g < N; g++) begin : g_pos
        qsd_digit_split u_split (
            .x_i     (digit_t'(a_i[g*DIGIT_W +: DIGIT_W])),
            .y_i     (digit_t'(b_eff[g*DIGIT_W +: DIGIT_W])),
            .carry_o (carry[g]),
            .part_o  (part[g])
        );
        if (g == 0) begin : g_low
            assign merged[g] = part[g];
        end else begin : g_mid
            qsd_digit_merge u_merge (
                .part_i  (part[g]),
                .carry_i (carry[g-1]),
                .digit_o (merged[g])
            );
        end
    end

    always_comb begin
        state_d = '0;
        for (int i = 0; i < N; i++) begin
            state_d.result[i*DIGIT_W +: DIGIT_W] = merged[i];
        end
        state_d.result[N*DIGIT_W +: DIGIT_W] = digit_t'(carry[N-1]);
    end

    assign res_next = state_d.result;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= '0;
            end else begin
                state_q <= state_d;
            end
        end
    end else begin : g_comb
        assign state_q = state_d;
    end

    assign sum_o = state_q.result;
endmodule

// File: rtl/qsd_adder_checker.sv
module qsd_adder_checker
    import qsd_pkg::*;
#(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int OPER_W = N * DIGIT_W,
    localparam int RES_W  = (N + 1) * DIGIT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sub_i,
    input logic [OPER_W-1:0] a_i,
    input logic [OPER_W-1:0] b_i,
    input logic [RES_W-1:0]  res_next,
    input logic [RES_W-1:0]  sum_o
);
    function automatic longint oper_val(logic [OPER_W-1:0] v);
        longint acc = 0;
        longint w   = 1;
        for (int i = 0; i < N; i++) begin
            acc = acc + longint'(digit_t'(v[i*DIGIT_W +: DIGIT_W])) * w;
            w   = w * 4;
        end
        return acc;
    endfunction

    function automatic longint res_val(logic [RES_W-1:0] v);
        longint acc = 0;
        longint w   = 1;
        for (int i = 0; i <= N; i++) begin
            acc = acc + longint'(digit_t'(v[i*DIGIT_W +: DIGIT_W])) * w;
            w   = w * 4;
        end
        return acc;
    endfunction

    longint exp_val;
    digit_t low_dig;
    digit_t top_dig;

    always_comb begin
        exp_val = sub_i ? (oper_val(a_i) - oper_val(b_i)) : (oper_val(a_i) + oper_val(b_i));
        low_dig = digit_t'(res_next[DIGIT_W-1:0]);
        top_dig = digit_t'(res_next[N*DIGIT_W +: DIGIT_W]);
    end

    for (genvar g = 0; g <= N; g++) begin : g_legal
        a_r2_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
            sum_o[g*DIGIT_W +: DIGIT_W] != DIGIT_BAD);
    end

    a_r3_add_value: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_i |-> res_val(res_next) == oper_val(a_i) + oper_val(b_i));

    a_r4_sub_value: assert property (@(posedge clk) disable iff (!rst_n)
        sub_i |-> res_val(res_next) == oper_val(a_i) - oper_val(b_i));

    a_r5_low_digit_small: assert property (@(posedge clk) disable iff (!rst_n)
        (low_dig >= -3'sd2) && (low_dig <= 3'sd2));

    a_r6_top_digit_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (top_dig == 3'sd0) || (top_dig == 3'sd1) || (top_dig == -3'sd1));

    if (REG_OUT) begin : g_lat
        a_r8_one_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> res_val(sum_o) == $past(exp_val));
    end
endmodule

bind qsd_adder qsd_adder_checker #(.N(N), .REG_OUT(REG_OUT)) u_qsd_adder_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_i    (sub_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .res_next (res_next),
    .sum_o    (sum_o)
);

// File: tb/qsd_adder_bench.sv
`timescale 1ns/1ps
module qsd_adder_bench;
    localparam int NB = 4;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                 sub4 = 1'b0;
    logic [NB*3-1:0]      a4 = '0;
    logic [NB*3-1:0]      b4 = '0;
    logic [(NB+1)*3-1:0]  s4;
    logic                 sub2 = 1'b0;
    logic [NS*3-1:0]      a2 = '0;
    logic [NS*3-1:0]      b2 = '0;
    logic [(NS+1)*3-1:0]  s2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    qsd_adder #(.N(NB)) u_qsd_adder (
        .clk(clk), .rst_n(rst_n), .sub_i(sub4), .a_i(a4), .b_i(b4), .sum_o(s4)
    );
    qsd_adder #(.N(NS)) u_qsd_adder_small (
        .clk(clk), .rst_n(rst_n), .sub_i(sub2), .a_i(a2), .b_i(b2), .sum_o(s2)
    );

    function automatic logic [2:0] enc(int d);
        return d[2:0];
    endfunction

    function automatic int dec(logic [26:0] v, int i);
        logic [2:0] d;
        d = v[i*3 +: 3];
        return int'($signed(d));
    endfunction

    function automatic int value(logic [26:0] v, int nd);
        int acc = 0;
        int w = 1;
        for (int i = 0; i < nd; i++) begin
            acc = acc + dec(v, i) * w;
            w = w * 4;
        end
        return acc;
    endfunction

    function automatic logic [26:0] fill(int d, int nd);
        logic [26:0] r = '0;
        for (int i = 0; i < nd; i++) r[i*3 +: 3] = enc(d);
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic verify(logic [26:0] a, logic [26:0] b, logic sub, logic [26:0] res, int nd);
        int cr[9];
        int pt[9];
        int raw;
        int y;
        int exp_d;
        for (int i = 0; i < nd; i++) begin
            y = sub ? -dec(b, i) : dec(b, i);
            raw = dec(a, i) + y;
            if (raw >= 3) begin cr[i] = 1; pt[i] = raw - 4; end
            else if (raw <= -3) begin cr[i] = -1; pt[i] = raw + 4; end
            else begin cr[i] = 0; pt[i] = raw; end
        end
        if (sub) check("R4 difference value", value(res, nd + 1), value(a, nd) - value(b, nd));
        else     check("R3 sum value", value(res, nd + 1), value(a, nd) + value(b, nd));
        for (int i = 0; i <= nd; i++) begin
            check("R2 no code 100", int'(res[i*3 +: 3] == 3'b100), 0);
        end
        check("R5 low digit", dec(res, 0), pt[0]);
        check("R6 top digit", dec(res, nd), cr[nd-1]);
        for (int i = 1; i < nd; i++) begin
            exp_d = pt[i] + cr[i-1];
            check("R7 middle digit", dec(res, i), exp_d);
        end
    endtask

    task automatic apply4(logic [NB*3-1:0] a, logic [NB*3-1:0] b, logic sub);
        @(negedge clk);
        a4 = a; b4 = b; sub4 = sub;
        @(negedge clk);
        verify(27'(a), 27'(b), sub, 27'(s4), NB);
    endtask

    initial begin
        // R1: reset with non-zero inputs present
        a4 = fill(3, NB); b4 = fill(3, NB);
        a2 = fill(-3, NS); b2 = fill(2, NS);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset wide", int'(s4 == '0), 1);
        check("R1 reset narrow", int'(s2 == '0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: new inputs applied away from the edge are not visible before it
        a4 = fill(1, NB); b4 = fill(2, NB); sub4 = 1'b0;
        #2;
        check("R8 held before edge", value(27'(s4), NB + 1), 2 * 255);
        @(negedge clk);
        check("R8 value after edge", value(27'(s4), NB + 1), 85 + 170);

        // Corner operands on the wide instance
        apply4(fill(3, NB), fill(3, NB), 1'b0);
        apply4(fill(-3, NB), fill(-3, NB), 1'b0);
        apply4(fill(3, NB), fill(-3, NB), 1'b1);
        apply4(fill(-3, NB), fill(3, NB), 1'b1);
        apply4(fill(3, NB), fill(3, NB), 1'b1);
        apply4(fill(0, NB), fill(0, NB), 1'b0);
        apply4(fill(2, NB), fill(1, NB), 1'b0);
        apply4(fill(-2, NB), fill(-1, NB), 1'b0);
        apply4(12'(fill(3, NB)) ^ 12'b000_111_000_111 ^ 12'b000_100_000_100, fill(3, NB), 1'b0);
        for (int k = 0; k < 300; k++) begin
            logic [NB*3-1:0] ra;
            logic [NB*3-1:0] rb;
            for (int i = 0; i < NB; i++) begin
                ra[i*3 +: 3] = enc(int'($urandom_range(0, 6)) - 3);
                rb[i*3 +: 3] = enc(int'($urandom_range(0, 6)) - 3);
            end
            apply4(ra, rb, 1'($urandom_range(0, 1)));
        end

        // Exhaustive sweep on the narrow instance
        for (int s = 0; s < 2; s++) begin
            for (int a1 = -3; a1 <= 3; a1++) begin
                for (int a0 = -3; a0 <= 3; a0++) begin
                    for (int b1 = -3; b1 <= 3; b1++) begin
                        for (int b0 = -3; b0 <= 3; b0++) begin
                            @(negedge clk);
                            a2 = {enc(a1), enc(a0)};
                            b2 = {enc(b1), enc(b0)};
                            sub2 = 1'(s);
                            @(negedge clk);
                            verify(27'(a2), 27'(b2), sub2, 27'(s2), NS);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule